// File: doc/BRIEF.md
# Parity Bus Transceiver

This block joins two byte-wide buses through a non-inverting bidirectional buffer and adds a parity unit that shares one pin between generating and checking. A direction input picks the source side. When the direction is transmit, side A feeds side B, and the block drives a parity bit onto the shared parity pin. When the direction is receive, side B feeds side A, and the block reads the parity pin and flags a mismatch on an active-low error output. An active-low enable floats every driven pin at once.

Each tri-state pin is split into an input, an output and a per-bit drive enable, so the block stays synthesizable and a pad ring can supply the real buffers. The block is purely combinational. Every result follows the current inputs within the same cycle. It has no state register, so it has no states or transitions to name. The two modes are transmit (`xfer_dir = 1`) and receive (`xfer_dir = 0`), and the enable gates both of them.

Top module: `bus_xcvr_parity`

## Requirements
- R1: With `en_n = 0` and `xfer_dir = 1`, every bit of `b_drv` is 1 and every bit of `a_drv` is 0. `b_out` equals `a_in` bit for bit, without inversion.
- R2: With `en_n = 0` and `xfer_dir = 0`, every bit of `a_drv` is 1 and every bit of `b_drv` is 0. `a_out` equals `b_in` bit for bit, without inversion.
- R3: With `en_n = 1`, `a_drv`, `b_drv` and `par_drv` are all 0, and `err_n` is 1 whatever the other inputs are.
- R4: In transmit with `odd_sel = 0` (even sense), `par_out` is 1 when `a_in` holds an odd number of ones and 0 otherwise. The nine bits together therefore hold an even count.
- R5: In transmit with `odd_sel = 1` (odd sense), `par_out` is the inverse of the even-sense value, so the nine bits hold an odd count.
- R6: In receive with `en_n = 0` and `odd_sel = 0`, `err_n` is 1 when `b_in` plus `par_in` hold an even number of ones, and 0 when they hold an odd number.
- R7: In receive with `en_n = 0` and `odd_sel = 1`, `err_n` is 1 when `b_in` plus `par_in` hold an odd number of ones, and 0 when they hold an even number.
- R8: `par_drv` is 1 only in transmit with `en_n = 0`. `err_n` is 1 throughout transmit, and `par_in` has no effect on any output in transmit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xfer_dir | input | 1 | 1 = transmit (A to B), 0 = receive (B to A) |
| en_n | input | 1 | Active-low enable; 1 floats all driven pins |
| odd_sel | input | 1 | Parity sense: 0 = even, 1 = odd |
| a_in | input | 8 | Value seen on side A pins |
| a_out | output | 8 | Value presented to side A pins |
| a_drv | output | 8 | Per-bit drive enable for side A |
| b_in | input | 8 | Value seen on side B pins |
| b_out | output | 8 | Value presented to side B pins |
| b_drv | output | 8 | Per-bit drive enable for side B |
| par_in | input | 1 | Value seen on the shared parity pin |
| par_out | output | 1 | Generated parity bit |
| par_drv | output | 1 | Drive enable for the parity pin |
| err_n | output | 1 | Active-low parity mismatch flag |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as its stimulus, with zero register stages on the path. Each task applies its inputs just after a rising clock edge. It reads the outputs at the following falling edge, half a period later, once every path has settled and well away from the edge. The parity cases cover zero, one, all and mixed set bits in both senses. The receive cases also flip the parity pin on each pattern, so both the error and no-error outcomes are observed.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned LANES = 8;

    typedef enum logic {
        XFER_RX = 1'b0,
        XFER_TX = 1'b1
    } xfer_dir_e;

    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } par_sense_e;

endpackage

// File: rtl/xcvr_parity_tree.sv
module xcvr_parity_tree #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] data,
    output logic             odd_ones
);
    localparam int unsigned STAGES = WIDTH + 1;

    logic [STAGES-1:0] chain;

    assign chain[0] = 1'b0;

    generate
        for (genvar gi = 0; gi < WIDTH; gi++) begin : g_xor
            assign chain[gi+1] = chain[gi] ^ data[gi];
        end
    endgenerate

    assign odd_ones = chain[STAGES-1];

    always_comb begin
        if (data == '0) begin
            a_r4_zero_even: assert (odd_ones == 1'b0);
        end
    end
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  xfer_dir_e        dir,
    input  logic             en_n,
    output logic [WIDTH-1:0] a_drv,
    output logic [WIDTH-1:0] b_drv,
    output logic             pin_drv
);
    logic live;

    always_comb begin
        live    = ~en_n;
        a_drv   = '0;
        b_drv   = '0;
        pin_drv = 1'b0;
        if (live) begin
            unique case (dir)
                XFER_TX: begin
                    b_drv   = '1;
                    pin_drv = 1'b1;
                end
                XFER_RX: begin
                    a_drv   = '1;
                end
            endcase
        end
    end

    always_comb begin
        a_r1_r2_one_side: assert (!((|a_drv) && (|b_drv)));
        if (en_n) begin
            a_r3_all_float: assert (a_drv == '0 && b_drv == '0 && !pin_drv);
        end
    end
endmodule

// File: rtl/xcvr_parity_unit.sv
module xcvr_parity_unit
    import xcvr_pkg::*;
(
    input  xfer_dir_e  dir,
    input  logic       en_n,
    input  par_sense_e sense,
    input  logic       tx_odd,
    input  logic       rx_odd,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       err_n
);
    logic sense_bit;
    logic rx_total_odd;

    always_comb begin
        sense_bit    = (sense == SENSE_ODD);
        pin_out      = tx_odd ^ sense_bit;
        rx_total_odd = rx_odd ^ pin_in;
        err_n        = 1'b1;
        if (!en_n && dir == XFER_RX) begin
            err_n = (rx_total_odd == sense_bit);
        end
    end

    always_comb begin
        if (dir == XFER_TX || en_n) begin
            a_r8_quiet_err: assert (err_n);
        end
    end
endmodule

// File: rtl/bus_xcvr_parity.sv
module bus_xcvr_parity
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = LANES
) (
    input  logic             xfer_dir,
    input  logic             en_n,
    input  logic             odd_sel,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_drv,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_drv,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_drv,
    output logic             err_n
);
    xfer_dir_e  dir;
    par_sense_e sense;
    logic       a_odd;
    logic       b_odd;

    assign dir   = xfer_dir_e'(xfer_dir);
    assign sense = par_sense_e'(odd_sel);

    assign b_out = a_in;
    assign a_out = b_in;

    xcvr_route #(.WIDTH(WIDTH)) u_route (
        .dir     (dir),
        .en_n    (en_n),
        .a_drv   (a_drv),
        .b_drv   (b_drv),
        .pin_drv (par_drv)
    );

    xcvr_parity_tree #(.WIDTH(WIDTH)) u_tree_a (
        .data     (a_in),
        .odd_ones (a_odd)
    );

    xcvr_parity_tree #(.WIDTH(WIDTH)) u_tree_b (
        .data     (b_in),
        .odd_ones (b_odd)
    );

    xcvr_parity_unit u_par (
        .dir     (dir),
        .en_n    (en_n),
        .sense   (sense),
        .tx_odd  (a_odd),
        .rx_odd  (b_odd),
        .pin_in  (par_in),
        .pin_out (par_out),
        .err_n   (err_n)
    );

    always_comb begin
        if (par_drv) begin
            a_r4_r5_nine_bits: assert (($countones({a_in, par_out}) % 2) == int'(odd_sel));
        end
        if (!en_n && !xfer_dir) begin
            a_r6_r7_check: assert (err_n == (($countones({b_in, par_in}) % 2) == int'(odd_sel)));
        end
    end
endmodule

// File: tb/bus_xcvr_parity_test.sv
module bus_xcvr_parity_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         xfer_dir, en_n, odd_sel, par_in;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, a_drv, b_out, b_drv;
    logic         par_out, par_drv, err_n;

    int n_checks = 0;
    int n_fails  = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    bus_xcvr_parity uut (
        .xfer_dir (xfer_dir),
        .en_n     (en_n),
        .odd_sel  (odd_sel),
        .a_in     (a_in),
        .a_out    (a_out),
        .a_drv    (a_drv),
        .b_in     (b_in),
        .b_out    (b_out),
        .b_drv    (b_drv),
        .par_in   (par_in),
        .par_out  (par_out),
        .par_drv  (par_drv),
        .err_n    (err_n)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic dir, input logic en, input logic odd,
                         input logic [W-1:0] a, input logic [W-1:0] b, input logic p);
        @(posedge clk);
        #1;
        xfer_dir = dir; en_n = en; odd_sel = odd;
        a_in = a; b_in = b; par_in = p;
        @(negedge clk);
    endtask

    task automatic t_idle;
        apply(1'b0, 1'b1, 1'b0, 8'h5A, 8'hC3, 1'b1);
        check("R3 a_drv idle", a_drv, '0);
        check("R3 b_drv idle", b_drv, '0);
        check("R3 par_drv idle", {7'b0, par_drv}, 8'h00);
        check("R3 err_n idle", {7'b0, err_n}, 8'h01);
        apply(1'b1, 1'b1, 1'b1, 8'hFF, 8'h01, 1'b0);
        check("R3 b_drv idle tx", b_drv, '0);
        check("R3 par_drv idle tx", {7'b0, par_drv}, 8'h00);
        check("R3 err_n idle tx", {7'b0, err_n}, 8'h01);
    endtask

    task automatic t_transmit(input logic [W-1:0] a, input logic odd);
        logic exp_par;
        exp_par = (($countones(a) % 2) == 1) ^ odd;
        for (int p = 0; p < 2; p++) begin
            apply(1'b1, 1'b0, odd, a, ~a, p[0]);
            check("R1 b_out", b_out, a);
            check("R1 b_drv", b_drv, '1);
            check("R1 a_drv", a_drv, '0);
            if (odd) check("R5 par_out odd", {7'b0, par_out}, {7'b0, exp_par});
            else     check("R4 par_out even", {7'b0, par_out}, {7'b0, exp_par});
            check("R8 par_drv tx", {7'b0, par_drv}, 8'h01);
            check("R8 err_n tx", {7'b0, err_n}, 8'h01);
        end
    endtask

    task automatic t_receive(input logic [W-1:0] b, input logic odd);
        logic exp_err_n;
        for (int p = 0; p < 2; p++) begin
            exp_err_n = (($countones({b, p[0]}) % 2) == 1) == odd;
            apply(1'b0, 1'b0, odd, ~b, b, p[0]);
            check("R2 a_out", a_out, b);
            check("R2 a_drv", a_drv, '1);
            check("R2 b_drv", b_drv, '0);
            check("R8 par_drv rx", {7'b0, par_drv}, 8'h00);
            if (odd) check("R7 err_n odd", {7'b0, err_n}, {7'b0, exp_err_n});
            else     check("R6 err_n even", {7'b0, err_n}, {7'b0, exp_err_n});
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        xfer_dir = 1'b0; en_n = 1'b1; odd_sel = 1'b0; par_in = 1'b0;
        a_in = '0; b_in = '0;
        t_idle();
        for (int s = 0; s < 2; s++) begin
            t_transmit(8'h00, s[0]);
            t_transmit(8'hFF, s[0]);
            t_transmit(8'h01, s[0]);
            t_transmit(8'hA5, s[0]);
            t_transmit(8'h7F, s[0]);
            t_receive(8'h00, s[0]);
            t_receive(8'h80, s[0]);
            t_receive(8'h3C, s[0]);
            t_receive(8'hFE, s[0]);
        end
        for (int v = 0; v < 32; v++) begin
            t_transmit(8'(v * 37 + 3), v[0]);
            t_receive(8'(v * 53 + 11), v[1]);
        end
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule